// File: doc/BRIEF.md
# Capture/Compare/PWM Counter Channel

This block is a single channel of a counter array. It takes a shared free-running counter, a strobe that marks the cycles on which the counter advanced, and one I/O pin. It keeps a capture/compare value of two register-width halves and a mode register. With these it can record the counter when the pin changes, raise a flag when the counter reaches a programmed value, invert its output pin on that match, generate a pulse-width-modulated waveform, or, on the designated watchdog channel, request a system reset.

Software reaches the channel through a write-only register port. Each register has its own address, and each address is offset by the channel index, so several instances on one bus each answer their own addresses. The channel state is visible on plain output ports. The interrupt flag stays set until software clears it. The counter and the interrupt controller sit outside the block.

Top module: `cch_channel`

## Requirements
- R1: After reset, the mode register reads 0x01 (comparator on, all other modes off), the capture value is 0, the flag is 0, the output pin is 1 and the reset request is 0.
- R2: Mode bit 1 (rising capture): on a tick where the sampled pin goes from 0 to 1, the counter is copied into the capture value and the flag is set on the following clock edge.
- R3: Mode bit 2 (falling capture): a 1-to-0 pin transition on a tick captures the counter and sets the flag. A transition in the direction that is not enabled captures nothing.
- R4: The pin is sampled only on tick cycles. A pin change between ticks is seen at the next tick, and a pulse that starts and ends between ticks is missed. In a cycle with neither a tick nor a register write, the capture value and the output pin hold.
- R5: Mode bit 3 (match flag): with mode bit 0 (comparator) set, a tick whose counter equals both capture halves sets the flag. A match on only one half sets nothing.
- R6: Mode bit 4 (toggle): with the comparator on, the match flag enabled and PWM off, each match inverts the output pin. Without the match flag enabled, the pin does not change.
- R7: Writing the low capture byte (address 0xEA+index) clears mode bit 0, and writing the high byte (0xFA+index) sets it. The other mode bits are unchanged. The mode register is at 0xDA+index.
- R8: Mode bit 5 (PWM): on a tick whose low counter half is zero, the low capture half is loaded from the high half. A write to the high half takes effect only at the next such point.
- R9: In PWM mode, after each tick the output pin is 0 when the low counter half is less than the (possibly just reloaded) low capture half, and 1 otherwise.
- R10: Only the channel whose index equals the watchdog index, and only while the watchdog enable input is high, turns a comparator match into a reset request. The request is a one-cycle pulse, and it does not depend on the match flag bit.
- R11: The flag stays set until the flag-clear input is high. If a set and a clear happen in the same cycle, the set wins.
- R12: If a capture and a software write to the low byte fall in the same cycle, the captured counter value is kept, and the write still clears mode bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advanced this cycle |
| cnt | input | 2*REG_W | Shared counter value |
| pin_in | input | 1 | Channel pin level |
| wdog_en | input | 1 | Watchdog enable from the counter mode register |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | REG_W | Register write data |
| flag_clr | input | 1 | Software clear of the channel flag |
| mode_q | output | REG_W | Mode register |
| cap_val | output | 2*REG_W | Capture/compare value {high, low} |
| flag | output | 1 | Channel interrupt flag |
| pin_out | output | 1 | Channel output pin |
| wdog_rst | output | 1 | One-cycle reset request |

## Verification
The bench uses a register width of 6, which makes the counter 12 bits wide. That brings every counter value within reach. The compare sweep walks all 4096 counter values for three targets, and each corner case is tested against a flag computed by equality in the bench. The PWM sweep covers a whole 64-step low-half period 64 times and changes the duty in the middle of a period. It checks the pin level and the reloaded low half against an arithmetic model. A second instance at channel index 1 shows that a match there never produces a reset request.

// File: rtl/cch_pkg.sv
package cch_pkg;
   // mode register bit positions
   localparam int MB_CMP   = 0;
   localparam int MB_RISE  = 1;
   localparam int MB_FALL  = 2;
   localparam int MB_MATCH = 3;
   localparam int MB_TOG   = 4;
   localparam int MB_PWM   = 5;
   localparam int MODE_BITS = 6;

   typedef struct packed {
      logic pwm;
      logic tog;
      logic match;
      logic fall;
      logic rise;
      logic cmp;
   } mode_t;
endpackage

// File: rtl/cch_pin_edge.sv
module cch_pin_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pin_in,
   output logic rise,
   output logic fall
);
   logic pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    pin_q <= 1'b0;
      else if (tick) pin_q <= pin_in;
   end

   assign rise = tick &  pin_in & ~pin_q;
   assign fall = tick & ~pin_in &  pin_q;
endmodule

// File: rtl/cch_regs.sv
module cch_regs
   import cch_pkg::*;
#(
   parameter int REG_W     = 8,
   parameter int ADDR_W    = 8,
   parameter int MODE_ADDR = 'hDA,
   parameter int LO_ADDR   = 'hEA,
   parameter int HI_ADDR   = 'hFA,
   localparam int CNT_W    = 2 * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              cap_evt,
   input  logic              reload,
   input  logic              flag_set,
   input  logic              flag_clr,
   output logic [REG_W-1:0]  mode_q,
   output logic [REG_W-1:0]  cap_lo,
   output logic [REG_W-1:0]  cap_hi,
   output logic              flag
);
   localparam logic [REG_W-1:0] MODE_RST = REG_W'(1) << MB_CMP;

   logic wr_mode, wr_lo, wr_hi;
   assign wr_mode = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
   assign wr_lo   = wr_en && (wr_addr == ADDR_W'(LO_ADDR));
   assign wr_hi   = wr_en && (wr_addr == ADDR_W'(HI_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
      end else if (wr_mode) begin
         mode_q <= wr_data;
      end else if (wr_lo) begin
         mode_q[MB_CMP] <= 1'b0;
      end else if (wr_hi) begin
         mode_q[MB_CMP] <= 1'b1;
      end
   end

   // hardware updates win over software writes
   always_ff @(posedge clk) begin
      if (!rst_n)       cap_lo <= '0;
      else if (cap_evt) cap_lo <= cnt[REG_W-1:0];
      else if (reload)  cap_lo <= cap_hi;
      else if (wr_lo)   cap_lo <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cap_hi <= '0;
      else if (cap_evt) cap_hi <= cnt[CNT_W-1:REG_W];
      else if (wr_hi)   cap_hi <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        flag <= 1'b0;
      else if (flag_set) flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   assert_capture_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> {cap_hi, cap_lo} == $past(cnt));   // also covers R3

   assert_capture_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && wr_lo) |=> (cap_lo == $past(cnt[REG_W-1:0])) && !mode_q[MB_CMP]);

   assert_lo_write_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> !mode_q[MB_CMP]);

   assert_hi_write_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> mode_q[MB_CMP]);

   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/cch_cmp_pwm.sv
module cch_cmp_pwm
   import cch_pkg::*;
#(
   parameter int REG_W  = 8,
   localparam int CNT_W = 2 * REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [REG_W-1:0] cap_lo,
   input  logic [REG_W-1:0] cap_hi,
   input  mode_t            mode,
   output logic             match_hit,
   output logic             reload,
   output logic             pin_out
);
   logic [REG_W-1:0] cnt_lo;
   logic [REG_W-1:0] eff_lo;

   assign cnt_lo    = cnt[REG_W-1:0];
   assign match_hit = tick && mode.cmp && (cnt == {cap_hi, cap_lo});
   assign reload    = tick && mode.pwm && (cnt_lo == '0);
   assign eff_lo    = reload ? cap_hi : cap_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_out <= 1'b1;
      end else if (tick && mode.pwm) begin
         pin_out <= (cnt_lo >= eff_lo);
      end else if (match_hit && mode.match && mode.tog) begin
         pin_out <= ~pin_out;
      end
   end

   assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (match_hit && mode.match && mode.tog && !mode.pwm) |=> pin_out != $past(pin_out));

   assert_pwm_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode.pwm && cnt_lo == '0 && cap_hi != '0) |=> !pin_out);
endmodule

// File: rtl/cch_wdog_pulse.sv
module cch_wdog_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   output logic pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= hit && !pulse;
   end
endmodule

// File: rtl/cch_channel.sv
module cch_channel
   import cch_pkg::*;
#(
   parameter int REG_W     = 8,
   parameter int ADDR_W    = 8,
   parameter int CHAN_IDX  = 0,
   parameter int NUM_CHAN  = 5,
   parameter int WDOG_IDX  = 4,
   parameter int MODE_BASE = 'hDA,
   parameter int LO_BASE   = 'hEA,
   parameter int HI_BASE   = 'hFA,
   localparam int CNT_W    = 2 * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              pin_in,
   input  logic              wdog_en,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic              flag_clr,
   output logic [REG_W-1:0]  mode_q,
   output logic [CNT_W-1:0]  cap_val,
   output logic              flag,
   output logic              pin_out,
   output logic              wdog_rst
);
   localparam int MODE_ADDR = MODE_BASE + CHAN_IDX;
   localparam int LO_ADDR   = LO_BASE + CHAN_IDX;
   localparam int HI_ADDR   = HI_BASE + CHAN_IDX;

   if (REG_W < MODE_BITS) begin : g_bad_width
      $error("REG_W must hold all mode bits");
   end
   if (CHAN_IDX >= NUM_CHAN || WDOG_IDX >= NUM_CHAN) begin : g_bad_index
      $error("channel index out of range");
   end
   if (HI_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register address does not fit ADDR_W");
   end

   mode_t            mode;
   logic             rise, fall, cap_evt, match_hit, reload, flag_set;
   logic [REG_W-1:0] cap_lo, cap_hi;

   assign mode.cmp   = mode_q[MB_CMP];
   assign mode.rise  = mode_q[MB_RISE];
   assign mode.fall  = mode_q[MB_FALL];
   assign mode.match = mode_q[MB_MATCH];
   assign mode.tog   = mode_q[MB_TOG];
   assign mode.pwm   = mode_q[MB_PWM];

   cch_pin_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .pin_in (pin_in),
      .rise   (rise),
      .fall   (fall)
   );

   assign cap_evt  = (rise && mode.rise) || (fall && mode.fall);
   assign flag_set = cap_evt || (match_hit && mode.match);

   cch_regs #(
      .REG_W     (REG_W),
      .ADDR_W    (ADDR_W),
      .MODE_ADDR (MODE_ADDR),
      .LO_ADDR   (LO_ADDR),
      .HI_ADDR   (HI_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wr_addr  (reg_addr),
      .wr_data  (reg_wdata),
      .cnt      (cnt),
      .cap_evt  (cap_evt),
      .reload   (reload),
      .flag_set (flag_set),
      .flag_clr (flag_clr),
      .mode_q   (mode_q),
      .cap_lo   (cap_lo),
      .cap_hi   (cap_hi),
      .flag     (flag)
   );

   cch_cmp_pwm #(.REG_W(REG_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cnt       (cnt),
      .cap_lo    (cap_lo),
      .cap_hi    (cap_hi),
      .mode      (mode),
      .match_hit (match_hit),
      .reload    (reload),
      .pin_out   (pin_out)
   );

   assign cap_val = {cap_hi, cap_lo};

   if (CHAN_IDX == WDOG_IDX) begin : g_wdog
      cch_wdog_pulse u_wdog (
         .clk   (clk),
         .rst_n (rst_n),
         .hit   (match_hit && wdog_en),
         .pulse (wdog_rst)
      );
   end else begin : g_no_wdog
      assign wdog_rst = 1'b0;
   end

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !reg_wr) |=> $stable(cap_val) && $stable(pin_out));

   assert_wdog_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |-> ($past(wdog_en) && $past(tick) && $past(mode_q[MB_CMP])
                    && $past(cnt) == $past(cap_val)));

   assert_wdog_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |=> !wdog_rst);

   assert_reset_state_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (cap_val == '0) && !flag && pin_out && !wdog_rst);
endmodule

// File: tb/cch_channel_bench.sv
module cch_channel_bench;
   localparam int REG_W = 6;
   localparam int CNT_W = 2 * REG_W;
   localparam int A_MODE = 'hDE;
   localparam int A_LO   = 'hEE;
   localparam int A_HI   = 'hFE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic [CNT_W-1:0] cnt = '0;
   logic pin_in = 1'b0;
   logic wdog_en = 1'b0;
   logic reg_wr = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic flag_clr = 1'b0;

   logic [REG_W-1:0] mode_q, mode_q1;
   logic [CNT_W-1:0] cap_val, cap_val1;
   logic flag, flag1, pin_out, pin_out1, wdog_rst, wdog_rst1;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cch_channel #(.REG_W(REG_W), .CHAN_IDX(4)) u_cch_channel (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .pin_in(pin_in),
      .wdog_en(wdog_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .flag_clr(flag_clr), .mode_q(mode_q),
      .cap_val(cap_val), .flag(flag), .pin_out(pin_out), .wdog_rst(wdog_rst)
   );

   cch_channel #(.REG_W(REG_W), .CHAN_IDX(1)) u_cch_channel_c1 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .pin_in(pin_in),
      .wdog_en(wdog_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .flag_clr(flag_clr), .mode_q(mode_q1),
      .cap_val(cap_val1), .flag(flag1), .pin_out(pin_out1), .wdog_rst(wdog_rst1)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int c, input bit t, input bit p, input bit fc,
                      input bit we, input int a, input int d);
      cnt = CNT_W'(c); tick = t; pin_in = p; flag_clr = fc;
      reg_wr = we; reg_addr = 8'(a); reg_wdata = REG_W'(d);
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0; flag_clr = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic wr(input int a, input int d);
      cyc(0, 1'b0, pin_in, 1'b0, 1'b1, a, d);
   endtask

   task automatic tk(input int c, input bit p);
      cyc(c, 1'b1, p, 1'b0, 1'b0, 0, 0);
   endtask

   task automatic clr();
      cyc(0, 1'b0, pin_in, 1'b1, 1'b0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int hi_m, lo_m, tgt;
      int tgts [3] = '{'h5A3, 'h000, 'hFFF};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mode", mode_q, 1);
      chk("R1 cap", cap_val, 0);
      chk("R1 flag", flag, 0);
      chk("R1 pin", pin_out, 1);
      chk("R1 wdog", wdog_rst, 0);

      // R2 rising capture
      wr(A_MODE, 2);
      tk(100, 1);
      chk("R2 cap", cap_val, 100);
      chk("R2 flag", flag, 1);
      clr();
      chk("R11 clear", flag, 0);
      tk(200, 0);
      chk("R3 fall ignored cap", cap_val, 100);
      chk("R3 fall ignored flag", flag, 0);

      // R3 falling capture
      wr(A_MODE, 4);
      tk(300, 1);
      chk("R3 rise ignored", cap_val, 100);
      tk(400, 0);
      chk("R3 cap", cap_val, 400);
      chk("R3 flag", flag, 1);
      clr();

      // R4 sampling only on ticks
      wr(A_MODE, 2);
      cyc(500, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0);
      chk("R4 no tick cap", cap_val, 400);
      chk("R4 no tick flag", flag, 0);
      tk(600, 1);
      chk("R4 late edge cap", cap_val, 600);
      clr();
      tk(700, 0);
      cyc(710, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0);
      cyc(720, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      tk(730, 0);
      chk("R4 glitch missed", cap_val, 600);
      chk("R4 glitch flag", flag, 0);

      // R11 sticky flag, set wins over clear
      tk(800, 1);
      repeat (3) tk(810, 1);
      chk("R11 sticky", flag, 1);
      tk(900, 0);
      cyc(1000, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0);
      chk("R11 set wins", flag, 1);
      clr();
      chk("R11 cleared", flag, 0);
      tk(1010, 0);

      // R5 compare sweep over every counter value
      foreach (tgts[i]) begin
         tgt = tgts[i];
         wr(A_LO, tgt % 64);
         wr(A_HI, tgt / 64);
         wr(A_MODE, 9);
         for (int v = 0; v < 4096; v++) begin
            tk(v, 0);
            chk("R5 match flag", flag, (v == tgt) ? 1 : 0);
            if (flag) clr();
         end
      end

      // R7 comparator enable by byte writes (target 0xFFF, mode 9)
      wr(A_LO, 'h3F);
      chk("R7 lo write clears cmp", mode_q, 8);
      tk('hFFF, 0);
      chk("R7 cmp off no flag", flag, 0);
      wr(A_HI, 'h3F);
      chk("R7 hi write sets cmp", mode_q, 9);
      tk('hFFF, 0);
      chk("R7 cmp on flag", flag, 1);
      clr();

      // R6 toggle
      wr(A_LO, 'h2C7 % 64);
      wr(A_HI, 'h2C7 / 64);
      wr(A_MODE, 'h19);
      tk('h2C6, 0);
      chk("R6 no match hold", pin_out, 1);
      tk('h2C7, 0);
      chk("R6 toggle low", pin_out, 0);
      tk('h2C7 ^ 'h040, 0);
      chk("R5 partial no flag", flag, 1);
      chk("R6 partial hold", pin_out, 0);
      tk('h2C7, 0);
      chk("R6 toggle high", pin_out, 1);
      clr();
      tk('h2C7 ^ 'h001, 0);
      chk("R5 low half only", flag, 0);
      wr(A_MODE, 'h11);
      tk('h2C7, 0);
      chk("R6 match flag off hold", pin_out, 1);
      chk("R5 match flag off", flag, 0);

      // R12 capture beats low byte write
      wr(A_MODE, 3);
      cyc('h3A5, 1'b1, 1'b1, 1'b0, 1'b1, A_LO, 'h11);
      chk("R12 captured kept", cap_val, 'h3A5);
      chk("R12 cmp cleared", mode_q, 2);
      clr();
      tk(0, 0);

      // R10 watchdog
      wr(A_LO, 'h155 % 64);
      wr(A_HI, 'h155 / 64);
      wr(A_MODE, 1);
      tk('h155, 0);
      chk("R10 no enable no reset", wdog_rst, 0);
      wdog_en = 1'b1;
      tk('h155, 0);
      chk("R10 reset pulse", wdog_rst, 1);
      chk("R10 flag untouched", flag, 0);
      tk('h155, 0);
      chk("R10 single pulse", wdog_rst, 0);
      tk('h156, 0);
      chk("R10 pulse gone", wdog_rst, 0);
      tk(0, 0);
      chk("R10 other channel", wdog_rst1, 0);
      chk("R10 main channel at 0", wdog_rst, 0);
      wdog_en = 1'b0;

      // R8/R9 PWM sweep with a duty change mid-period
      hi_m = 20; lo_m = 0;
      wr(A_HI, hi_m);
      wr(A_MODE, 32);
      for (int v = 0; v < 4096; v++) begin
         if (v == 2000) begin
            wr(A_HI, 45);
            hi_m = 45;
         end
         tk(v, 0);
         if (v % 64 == 0) lo_m = hi_m;
         chk("R8 reload", cap_val % 64, lo_m);
         chk("R9 pwm level", pin_out, ((v % 64) >= lo_m) ? 1 : 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule